// File: doc/BRIEF.md
# Learned Page Admission Controller

This block tracks which pages of a small page space sit in a fully associative set of cache slots, and decides on every miss whether the missing page deserves a slot at all. Each page carries a signed 8-bit weight for each of 16 program modes. A performance unit strobes an evaluation with a current and a previous run measurement. A better run raises the weight of every resident page in the active mode, and a worse run lowers it. A page's score is its weight in the active mode, plus a leaky hit counter kept for its slot, plus a small pseudo-random offset.

A reference to a resident page is a hit. On a miss an empty slot is always taken first. With every slot full, the page is admitted only when some resident page scores below a software-set threshold, and the lowest-scoring such page is evicted. Otherwise the reference is served uncached and the slots stay as they are. Hit, miss, admit and the chosen slot are reported combinationally in the cycle of the reference. The change to the slots is committed on the following clock edge.

Top module: `page_admit_ctrl`

## Requirements
- R1: While `ref_valid` is high, `ref_hit` is high exactly when a valid slot holds `ref_page`, `ref_miss` is its complement, and `ref_slot` gives the hit slot. While `ref_valid` is low both flags are low. All of these are combinational.
- R2: On a miss with at least one empty slot, `ref_admit` is high and `ref_slot` names the lowest-index empty slot. On the next edge that slot becomes valid with the page and an activity count of 0.
- R3: With all slots full, each slot's score is the signed sum of its page's weight in the active mode, its activity count and the noise offset. A miss is admitted only if some score is below the signed threshold. The victim is the lowest score, with ties going to the lowest index. The victim's slot takes the new page with activity 0 on the next edge.
- R4: A miss that is not admitted changes no slot: the same references then hit or miss exactly as before.
- R5: On `eval_stb`, the active-mode weight of every page resident at that edge changes by +1 when `perf_now > perf_last` and by -1 when it is lower. The comparison is unsigned. When the two are equal, no weight changes.
- R6: Weights saturate at +127 and -128 and never wrap.
- R7: A slot's activity count rises by 1 on each hit, saturating at 15, and halves on each `eval_stb`. In a cycle with both, the halving comes first.
- R8: The noise is the low 3 bits, taken as unsigned, of a 16-bit LFSR. The LFSR resets to 0xACE1 and shifts left once per cycle with `ref_valid` high. The new bit 0 is bit15^bit13^bit12^bit10.
- R9: `mode_we` loads the 4-bit mode and `thr_we` loads the signed threshold. Each takes effect from the next cycle.
- R10: After reset no slot is valid, every weight is 0, the mode is 0 and the threshold equals `THR_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | MODE_W | New program mode |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | SCORE_W | New signed threshold |
| perf_now | input | PERF_W | Current run measurement |
| perf_last | input | PERF_W | Previous run measurement |
| eval_stb | input | 1 | Evaluation strobe |
| ref_valid | input | 1 | Page reference present |
| ref_page | input | PAGE_W | Referenced page number |
| ref_hit | output | 1 | Reference hits a resident page |
| ref_miss | output | 1 | Reference misses |
| ref_admit | output | 1 | Missed page will be placed in a slot |
| ref_slot | output | SLOT_IW | Hit slot or target slot |

## Verification
The bench builds the block with four slots and a 4-bit page number. Sixteen pages then compete for four slots, so fills, evictions and bypasses all happen often under random references. Long directed runs of evaluation strobes drive the active-mode weights into both saturation limits. Those saturated weights move the threshold decision one way or the other, and mode switches move it back. The bench keeps its own model of the weights, the activity counts and the noise sequence, and it predicts every outcome and every slot index from that model.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam logic [15:0] NOISE_SEED = 16'hACE1;

  function automatic logic [15:0] noise_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pac_noise.sv
module pac_noise
  import pac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [2:0] offset
);
  logic [15:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = noise_step(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= NOISE_SEED;
    else        st_q <= st_d;
  end

  assign offset = st_q[2:0];

  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n) st_q != 16'h0)
    else $error("noise register reached the all-zero lock state");
endmodule

// File: rtl/pac_weight_store.sv
module pac_weight_store #(
  parameter int N_SLOTS  = 4,
  parameter int PAGE_W   = 6,
  parameter int MODE_W   = 4,
  parameter int WEIGHT_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [MODE_W-1:0]                    mode,
  input  logic [N_SLOTS-1:0][PAGE_W-1:0]       slot_page,
  input  logic [N_SLOTS-1:0]                   slot_vld,
  input  logic                                 upd_en,
  input  logic                                 upd_up,
  output logic [N_SLOTS-1:0][WEIGHT_W-1:0]     rd_w
);
  localparam int ENTRIES = (1 << PAGE_W) * (1 << MODE_W);
  localparam int IDX_W   = PAGE_W + MODE_W;
  localparam logic [WEIGHT_W-1:0] W_MAX = {1'b0, {(WEIGHT_W-1){1'b1}}};
  localparam logic [WEIGHT_W-1:0] W_MIN = {1'b1, {(WEIGHT_W-1){1'b0}}};

  logic [WEIGHT_W-1:0] mem_q [ENTRIES];
  logic [WEIGHT_W-1:0] mem_d [ENTRIES];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_rd
    assign rd_w[g] = mem_q[IDX_W'({slot_page[g], mode})];
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) mem_d[e] = mem_q[e];
    if (upd_en) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (slot_vld[i]) begin
          if (upd_up && (rd_w[i] != W_MAX))
            mem_d[IDX_W'({slot_page[i], mode})] = rd_w[i] + 1'b1;
          else if (!upd_up && (rd_w[i] != W_MIN))
            mem_d[IDX_W'({slot_page[i], mode})] = rd_w[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= mem_d[e];
    end
  end

  // R6: a saturated weight of a resident slot page holds at the limit
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_up && slot_vld[0] && rd_w[0] == W_MAX)
      |=> (mem_q[IDX_W'({$past(slot_page[0]), $past(mode)})] == W_MAX))
    else $error("weight wrapped past the upper limit");
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_up && slot_vld[0] && rd_w[0] == W_MIN)
      |=> (mem_q[IDX_W'({$past(slot_page[0]), $past(mode)})] == W_MIN))
    else $error("weight wrapped past the lower limit");
endmodule

// File: rtl/pac_victim_sel.sv
module pac_victim_sel #(
  parameter int N_SLOTS = 4,
  parameter int SCORE_W = 10,
  localparam int SLOT_IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [N_SLOTS-1:0]                      slot_vld,
  input  logic [N_SLOTS-1:0][SCORE_W-1:0]         score,
  input  logic signed [SCORE_W-1:0]               thr,
  output logic                                    has_empty,
  output logic [SLOT_IW-1:0]                      empty_idx,
  output logic                                    below_any,
  output logic [SLOT_IW-1:0]                      min_idx
);
  logic signed [SCORE_W-1:0] min_sc;

  always_comb begin
    has_empty = 1'b0;
    empty_idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        has_empty = 1'b1;
        empty_idx = SLOT_IW'(i);
      end
    end
  end

  always_comb begin
    below_any = 1'b0;
    min_idx   = '0;
    min_sc    = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (slot_vld[i] && ($signed(score[i]) < thr) &&
          (!below_any || ($signed(score[i]) < min_sc))) begin
        below_any = 1'b1;
        min_idx   = SLOT_IW'(i);
        min_sc    = $signed(score[i]);
      end
    end
  end
endmodule

// File: rtl/page_admit_ctrl.sv
module page_admit_ctrl
  import pac_pkg::*;
#(
  parameter int N_SLOTS  = 4,
  parameter int PAGE_W   = 6,
  parameter int MODE_W   = 4,
  parameter int WEIGHT_W = 8,
  parameter int ACT_W    = 4,
  parameter int PERF_W   = 16,
  parameter int THR_RST  = 0,
  localparam int SCORE_W = WEIGHT_W + 2,
  localparam int SLOT_IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_we,
  input  logic [MODE_W-1:0]    mode_wdata,
  input  logic                 thr_we,
  input  logic [SCORE_W-1:0]   thr_wdata,
  input  logic [PERF_W-1:0]    perf_now,
  input  logic [PERF_W-1:0]    perf_last,
  input  logic                 eval_stb,
  input  logic                 ref_valid,
  input  logic [PAGE_W-1:0]    ref_page,
  output logic                 ref_hit,
  output logic                 ref_miss,
  output logic                 ref_admit,
  output logic [SLOT_IW-1:0]   ref_slot
);
  // slot state
  logic [N_SLOTS-1:0][PAGE_W-1:0] page_q, page_d;
  logic [N_SLOTS-1:0]             vld_q, vld_d;
  logic [N_SLOTS-1:0][ACT_W-1:0]  act_q, act_d;
  logic [MODE_W-1:0]              mode_q, mode_d;
  logic [SCORE_W-1:0]             thr_q, thr_d;

  logic [N_SLOTS-1:0]                match;
  logic [SLOT_IW-1:0]                hit_idx;
  logic [N_SLOTS-1:0][WEIGHT_W-1:0]  w_rd;
  logic [N_SLOTS-1:0][SCORE_W-1:0]   score;
  logic [2:0]                        noise;
  logic                              has_empty, below_any;
  logic [SLOT_IW-1:0]                empty_idx, min_idx, tgt_idx;
  logic                              upd_en, upd_up;

  // lookup
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (page_q[g] == ref_page);
    assign score[g] = SCORE_W'($signed(w_rd[g]))
                    + SCORE_W'(act_q[g])
                    + SCORE_W'(noise);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N_SLOTS; i++) if (match[i]) hit_idx = SLOT_IW'(i);
  end

  assign ref_hit   = ref_valid && (|match);
  assign ref_miss  = ref_valid && !(|match);
  assign tgt_idx   = has_empty ? empty_idx : min_idx;
  assign ref_admit = ref_miss && (has_empty || below_any);
  assign ref_slot  = ref_hit ? hit_idx : (ref_admit ? tgt_idx : '0);

  pac_noise u_noise (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (ref_valid),
    .offset (noise)
  );

  pac_victim_sel #(.N_SLOTS(N_SLOTS), .SCORE_W(SCORE_W)) u_vsel (
    .slot_vld  (vld_q),
    .score     (score),
    .thr       ($signed(thr_q)),
    .has_empty (has_empty),
    .empty_idx (empty_idx),
    .below_any (below_any),
    .min_idx   (min_idx)
  );

  assign upd_en = eval_stb && (perf_now != perf_last);
  assign upd_up = perf_now > perf_last;

  pac_weight_store #(
    .N_SLOTS(N_SLOTS), .PAGE_W(PAGE_W), .MODE_W(MODE_W), .WEIGHT_W(WEIGHT_W)
  ) u_wstore (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .slot_page (page_q),
    .slot_vld  (vld_q),
    .upd_en    (upd_en),
    .upd_up    (upd_up),
    .rd_w      (w_rd)
  );

  // next state
  always_comb begin
    page_d = page_q;
    vld_d  = vld_q;
    mode_d = mode_we ? mode_wdata : mode_q;
    thr_d  = thr_we ? thr_wdata : thr_q;
    for (int i = 0; i < N_SLOTS; i++) begin
      act_d[i] = eval_stb ? (act_q[i] >> 1) : act_q[i];
      if (ref_hit && hit_idx == SLOT_IW'(i) && act_d[i] != '1)
        act_d[i] = act_d[i] + 1'b1;
      if (ref_admit && tgt_idx == SLOT_IW'(i)) begin
        page_d[i] = ref_page;
        vld_d[i]  = 1'b1;
        act_d[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      vld_q  <= '0;
      act_q  <= '0;
      mode_q <= '0;
      thr_q  <= SCORE_W'(THR_RST);
    end else begin
      page_q <= page_d;
      vld_q  <= vld_d;
      act_q  <= act_d;
      mode_q <= mode_d;
      thr_q  <= thr_d;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_valid |-> (!ref_hit && !ref_miss && !ref_admit))
    else $error("outcome flags raised without a reference");
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match))
    else $error("page resident in more than one slot");
  p_empty_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_admit && !(&vld_q)) |-> !vld_q[ref_slot])
    else $error("occupied slot replaced while an empty slot exists");
  p_admit_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_admit |=> (vld_q[$past(ref_slot)] && page_q[$past(ref_slot)] == $past(ref_page)))
    else $error("admitted page not placed in the chosen slot");
  p_bypass_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_miss && !ref_admit) |=> ($stable(page_q) && $stable(vld_q)))
    else $error("bypassed miss altered the slots");
endmodule

// File: tb/page_admit_ctrl_tb_top.sv
module page_admit_ctrl_tb_top;
  localparam int NS = 4;
  localparam int PW = 4;
  localparam int NP = 1 << PW;
  localparam int NM = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_we;
  logic [3:0] mode_wdata;
  logic       thr_we;
  logic [9:0] thr_wdata;
  logic [15:0] perf_now, perf_last;
  logic       eval_stb;
  logic       ref_valid;
  logic [PW-1:0] ref_page;
  logic       ref_hit, ref_miss, ref_admit;
  logic [1:0] ref_slot;

  int checks = 0;
  int errors = 0;

  // bench model
  int m_w [NP][NM];
  int m_pg [NS];
  bit m_v [NS];
  int m_act [NS];
  logic [15:0] m_lfsr;
  int m_mode;
  int m_thr;

  always #2 clk = ~clk;

  page_admit_ctrl #(.N_SLOTS(NS), .PAGE_W(PW), .THR_RST(0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .perf_now(perf_now), .perf_last(perf_last), .eval_stb(eval_stb),
    .ref_valid(ref_valid), .ref_page(ref_page),
    .ref_hit(ref_hit), .ref_miss(ref_miss), .ref_admit(ref_admit), .ref_slot(ref_slot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    summary_and_end();
  end

  function automatic int clamp_w(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // one cycle: drive at negedge, check before posedge, update model after it
  task automatic cyc(input string req, input bit mwe, input int md, input bit twe, input int td,
                     input int pn, input int pl, input bit ev, input bit rv, input int pg);
    int hidx, tgt, best, sc;
    bit hit, adm, anyempty;
    @(negedge clk);
    mode_we = mwe; mode_wdata = 4'(md);
    thr_we = twe; thr_wdata = 10'(td);
    perf_now = 16'(pn); perf_last = 16'(pl);
    eval_stb = ev; ref_valid = rv; ref_page = PW'(pg);
    #1;
    hit = 0; hidx = 0; adm = 0; tgt = 0; anyempty = 0;
    for (int i = 0; i < NS; i++) if (m_v[i] && m_pg[i] == pg) begin hit = 1; hidx = i; end
    if (rv && !hit) begin
      for (int i = NS - 1; i >= 0; i--) if (!m_v[i]) begin anyempty = 1; tgt = i; end
      if (anyempty) adm = 1;
      else begin
        best = 0;
        for (int i = 0; i < NS; i++) begin
          sc = m_w[m_pg[i]][m_mode] + m_act[i] + int'(m_lfsr[2:0]);
          if (sc < m_thr && (!adm || sc < best)) begin adm = 1; best = sc; tgt = i; end
        end
      end
    end
    if (!rv) begin
      chk("R1", "idle hit", int'(ref_hit), 0);
      chk("R1", "idle miss", int'(ref_miss), 0);
    end else begin
      chk("R1", "hit", int'(ref_hit), int'(hit));
      chk("R1", "miss", int'(ref_miss), int'(!hit));
      if (hit) chk("R1", "hit slot", int'(ref_slot), hidx);
      else begin
        chk(anyempty ? "R2" : (adm ? req : "R4"), "admit", int'(ref_admit), int'(adm));
        if (adm) chk(anyempty ? "R2" : req, "target slot", int'(ref_slot), tgt);
      end
    end
    @(posedge clk);
    // model update
    if (ev && pn != pl)
      for (int i = 0; i < NS; i++)
        if (m_v[i]) m_w[m_pg[i]][m_mode] = clamp_w(m_w[m_pg[i]][m_mode] + ((pn > pl) ? 1 : -1));
    for (int i = 0; i < NS; i++) begin
      if (ev) m_act[i] = m_act[i] / 2;
      if (rv && hit && hidx == i && m_act[i] < 15) m_act[i]++;
    end
    if (rv && !hit && adm) begin m_pg[tgt] = pg; m_v[tgt] = 1; m_act[tgt] = 0; end
    if (rv) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    if (mwe) m_mode = md;
    if (twe) m_thr = td;
  endtask

  task automatic ref_only(input string req, input int pg);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 1, pg);
  endtask

  task automatic strobe(input string req, input int pn, input int pl);
    cyc(req, 0, 0, 0, 0, pn, pl, 1, 0, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0A1C);
    rst_n = 0; mode_we = 0; mode_wdata = 0; thr_we = 0; thr_wdata = 0;
    perf_now = 0; perf_last = 0; eval_stb = 0; ref_valid = 0; ref_page = 0;
    for (int p = 0; p < NP; p++) for (int m = 0; m < NM; m++) m_w[p][m] = 0;
    for (int i = 0; i < NS; i++) begin m_pg[i] = 0; m_v[i] = 0; m_act[i] = 0; end
    m_lfsr = 16'hACE1; m_mode = 0; m_thr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10: reset state, nothing resident, first misses fill slots in order
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int p = 1; p <= 4; p++) ref_only("R10", p);
    // R1: hits on resident pages
    ref_only("R1", 2); ref_only("R1", 4);
    // R4: scores >= 0 with threshold 0, miss bypasses and stays a miss
    ref_only("R4", 9); ref_only("R4", 9); ref_only("R4", 1);
    // R5: equal performance leaves weights alone
    for (int k = 0; k < 50; k++) strobe("R5", 7, 7);
    ref_only("R5", 10);
    // R6: drive weights to the upper limit, no wrap into negatives
    for (int k = 0; k < 140; k++) strobe("R6", 9, 3);
    ref_only("R6", 11);
    cyc("R6", 0, 0, 1, 130, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) ref_only("R6", 12 + (k % 3));
    // R9: mode switch exposes zero weights of mode 3
    cyc("R9", 1, 3, 1, 5, 0, 0, 0, 0, 0);
    ref_only("R9", 6); ref_only("R9", 7);
    cyc("R9", 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R6: lower limit
    for (int k = 0; k < 300; k++) strobe("R6", 2, 40000);
    cyc("R6", 0, 0, 1, -121, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) ref_only("R6", k + 8);
    // R7: activity build-up and halving with simultaneous hits
    cyc("R7", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 20; k++) cyc("R7", 0, 0, 0, 0, 5, 5, (k % 4) == 0, 1, m_pg[k % NS]);
    // R8: noise decides references near threshold
    cyc("R8", 1, 5, 1, 3, 0, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) ref_only("R8", k % NP);

    // R3: constrained random mix
    for (int k = 0; k < 4000; k++) begin
      int pn, pl, td;
      bit ev, rv, mwe, twe;
      rv  = ($urandom % 10) < 7;
      ev  = ($urandom % 20) == 0;
      mwe = ($urandom % 50) == 0;
      twe = ($urandom % 30) == 0;
      pn  = $urandom % 8;
      pl  = $urandom % 8;
      td  = int'($urandom % 60) - 20;
      cyc("R3", mwe, $urandom % 4, twe, td, pn, pl, ev, rv, $urandom % NP);
    end

    summary_and_end();
  end
endmodule